// File: doc/BRIEF.md
# Serial ADC Single-Sample Reader

This block is a serial-bus master that pulls one 10-bit conversion out of a single-channel serial converter. A one-cycle start strobe opens a frame. Chip select goes low and sixteen serial clocks are sent, as two 8-bit segments. The data line is sampled on every rising serial-clock edge. Chip select is then released and the 10-bit value is presented together with a one-cycle done pulse.

The converter drives nothing useful on the first two clocks. It then sends a zero bit and the ten result bits, most significant first. After those it begins to send the low bits again in reverse order. The reader first collects all sixteen sampled bits into a raw word. It then drops the three leading bits and the three repeated trailing bits, which leaves the value right-justified. The serial clock can idle low or idle high, and in both cases the rising edge is the sampling edge. The serial clock rate is set by a divider input that gives the length of one half period in system clocks.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, and in the cycle after it, `cs_n` is 1, `done` is 0 and `sample` is 0.
- R2: A `start` accepted in idle pulls `cs_n` low in the next cycle. `cs_n` stays low through every serial-clock edge of the frame.
- R3: Every frame contains exactly 16 rising and 16 falling `sclk` edges.
- R4: When no frame is running, `sclk` rests at the level given by `idle_high` (0 = rests low, 1 = rests high). It is back at that level when `cs_n` rises.
- R5: Each `sclk` level lasts `half_div`+1 system clocks. This also holds for the interval from the fall of `cs_n` to the first edge.
- R6: `sdi` is sampled on each rising `sclk` edge. Call the bit taken at the k-th rising edge s_k (k = 1..16). The result is s_4..s_13, with s_4 as bit 9 and s_13 as bit 0.
- R7: The values of s_1, s_2, the null bit s_3 and the repeated bits s_14..s_16 have no effect on `sample`.
- R8: `done` is high for one cycle, in the cycle where `cs_n` returns high. `sample` changes only in that cycle.
- R9: A `start` that arrives while a frame is in progress is ignored. The frame keeps its timing and produces exactly one `done`.
- R10: `cs_n` rises no earlier than one half period after the last `sclk` edge. It stays high for at least one half period before the next frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read a sample |
| half_div | input | DIV_W | Half-period length of `sclk`, minus one, in system clocks |
| idle_high | input | 1 | Serial clock rest level: 0 low, 1 high |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| sample | output | 10 | Last right-justified conversion result |
| done | output | 1 | One-cycle pulse when `sample` is updated |

## Verification
The assertions assume two things about the inputs. First, `half_div` and `idle_high` are captured at the accepted start, so changing them mid-frame has no effect. Second, `idle_high` changes only while the reader is idle, which means an `sclk` change with `cs_n` high can only come from a change of rest level. The stimulus changes both settings only after the previous `done` and then waits longer than the release gap before it checks the rest level. An ADC model advances one bit for each rising edge it sees while chip select is low. In some frames it fills the ignored positions with inverted or set bits. One frame repeats `start` in the middle of the frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    // Frame geometry fixed by the converter's serial protocol
    localparam int SEG_BITS   = 8;
    localparam int SEG_COUNT  = 2;
    localparam int FRAME_BITS = SEG_BITS * SEG_COUNT;
    localparam int RES_BITS   = 10;
    localparam int LEAD_BITS  = 3;   // two undriven bits plus the null bit
    localparam int TAIL_BITS  = FRAME_BITS - LEAD_BITS - RES_BITS;
    localparam int EDGES      = 2 * FRAME_BITS;
    localparam int EDGE_W     = $clog2(EDGES);

    typedef logic [FRAME_BITS-1:0] raw_t;
    typedef logic [RES_BITS-1:0]   res_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_GAP
    } phase_e;

    typedef struct packed {
        logic [SEG_BITS-1:0] hi;
        logic [SEG_BITS-1:0] lo;
    } frame_s;

    // Remove the repeated low bits by a right shift of the joined segments.
    // The low bits of the first segment then fall next to the surviving bits
    // of the second, and the junk lead bits drop off the top through the truncation.
    function automatic res_t repack(frame_s f);
        raw_t joined;
        joined = {f.hi, f.lo} >> TAIL_BITS;
        return joined[RES_BITS-1:0];
    endfunction

endpackage

// File: rtl/adcrd_halfper_timer.sv
module adcrd_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = !load && (cnt_q == '0);
endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen
    import adcrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic idle_level,
    input  logic step,
    output logic sclk,
    output logic rise,
    output logic last
);
    logic              sclk_q;
    logic [EDGE_W-1:0] edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            edge_q <= '0;
        end else if (idle) begin
            sclk_q <= idle_level;
            edge_q <= '0;
        end else if (step) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
        end
    end

    assign sclk = sclk_q;
    assign rise = step && !sclk_q;
    assign last = step && (edge_q == EDGE_W'(EDGES - 1));
endmodule

// File: rtl/adcrd_shift_in.sv
module adcrd_shift_in
    import adcrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift,
    input  logic din,
    output raw_t word
);
    raw_t sr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], din};
        end
    end

    assign word = sr_q;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                idle_high,
    input  logic                sdi,
    output logic                cs_n,
    output logic                sclk,
    output logic [RES_BITS-1:0] sample,
    output logic                done
);
    phase_e           st_q;
    logic [DIV_W-1:0] div_q;
    logic             mode_q;
    logic             cs_q;
    logic             done_q;
    res_t             sample_q;

    logic             idle;
    logic             accept;
    logic             tick;
    logic             step;
    logic             rise;
    logic             last_edge;
    logic [DIV_W-1:0] reload;
    raw_t             raw;
    frame_s           frame;

    assign idle   = (st_q == ST_IDLE);
    assign accept = idle && start;
    assign reload = idle ? half_div : div_q;
    assign step   = tick && (st_q == ST_RUN);
    assign frame  = frame_s'(raw);

    adcrd_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (idle),
        .reload (reload),
        .tick   (tick)
    );

    adcrd_sclk_gen u_sclk (
        .clk        (clk),
        .rst        (rst),
        .idle       (idle),
        .idle_level (idle_high),
        .step       (step),
        .sclk       (sclk),
        .rise       (rise),
        .last       (last_edge)
    );

    adcrd_shift_in u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .shift (rise),
        .din   (sdi),
        .word  (raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            div_q    <= '0;
            mode_q   <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b0;
            sample_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_RUN;
                        cs_q   <= 1'b0;
                        div_q  <= half_div;
                        mode_q <= idle_high;
                    end
                end
                ST_RUN: begin
                    if (last_edge) st_q <= ST_TAIL;
                end
                ST_TAIL: begin
                    if (tick) begin
                        st_q     <= ST_GAP;
                        cs_q     <= 1'b1;
                        done_q   <= 1'b1;
                        sample_q <= repack(frame);
                    end
                end
                ST_GAP: begin
                    if (tick) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n   = cs_q;
    assign done   = done_q;
    assign sample = sample_q;
endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker
    import adcrd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                cs_n,
    input logic                sclk,
    input logic                done,
    input logic [RES_BITS-1:0] sample,
    input logic                mode_q,
    input logic [DIV_W-1:0]    div_q,
    input phase_e              st_q
);
    logic             sclk_d;
    logic [5:0]       rise_cnt;
    logic [DIV_W:0]   gap_cnt;
    logic [DIV_W+1:0] hi_cnt;
    logic             busy;

    assign busy = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            gap_cnt  <= '0;
            hi_cnt   <= '1;
        end else begin
            sclk_d <= sclk;
            if (cs_n) begin
                rise_cnt <= '0;
                gap_cnt  <= '0;
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
                if (sclk != sclk_d) gap_cnt <= 1;
                else                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    p_cs_start_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(start));

    p_edges_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && sclk != sclk_d) |-> !cs_n);

    p_edge_count_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> rise_cnt == 6'(FRAME_BITS));

    p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sclk == mode_q);

    p_halfper_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sclk != sclk_d) |-> gap_cnt == ({1'b0, div_q} + 1'b1));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_cs_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    p_sample_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(sample));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(mode_q) && $stable(div_q)));

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> hi_cnt > {2'b00, $past(div_q)});
endmodule

bind adc_frame_reader adcrd_checker #(.DIV_W(DIV_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .done   (done),
    .sample (sample),
    .mode_q (mode_q),
    .div_q  (div_q),
    .st_q   (st_q)
);

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [DIV_W-1:0] half_div;
    logic             idle_high;
    logic             sdi;
    logic             cs_n;
    logic             sclk;
    logic [9:0]       sample;
    logic             done;

    always #2 clk = ~clk;

    adc_frame_reader #(.DIV_W(DIV_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .half_div  (half_div),
        .idle_high (idle_high),
        .sdi       (sdi),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample    (sample),
        .done      (done)
    );

    int nchk  = 0;
    int nfail = 0;

    logic [9:0] exp_q[$];

    // Converter model: the bit at word[15-idx] is on the line
    logic [15:0] word = '0;
    int          idx  = 0;
    assign sdi = (idx < 16) ? word[15 - idx] : 1'b0;

    // Monitor state
    logic sclk_p, cs_p, done_p;
    logic [9:0] res_p;
    int rises, falls, gap, hp_err, cs_hi, res_moves;
    int cur_h  = 1;
    int last_h = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            idx = 0; sclk_p = sclk; cs_p = 1'b1; done_p = 1'b0; res_p = '0;
            rises = 0; falls = 0; gap = 0; hp_err = 0; cs_hi = 1000; res_moves = 0;
        end else begin
            if (cs_n) idx = 0;
            else if (sclk && !sclk_p) idx = idx + 1;

            if (!cs_n) begin
                if (cs_p) begin
                    chk(cs_hi >= last_h, "R10", cs_hi, last_h, "chip select high gap");
                    rises = 0; falls = 0; hp_err = 0; gap = 0;
                end
                if (sclk != sclk_p) begin
                    if (gap != cur_h) hp_err++;
                    if (sclk) rises++; else falls++;
                    gap = 1;
                end else begin
                    gap++;
                end
                cs_hi = 0;
            end else begin
                if (!cs_p) begin
                    chk(gap >= cur_h, "R10", gap, cur_h, "last edge to chip select rise");
                    chk(done === 1'b1, "R8", int'(done), 1, "done with chip select rise");
                    chk(rises == 16, "R3", rises, 16, "rising edges");
                    chk(falls == 16, "R3", falls, 16, "falling edges");
                    chk(hp_err == 0, "R5", hp_err, 0, "half period errors");
                    chk(res_moves == 0, "R8", res_moves, 0, "sample moved outside done");
                    res_moves = 0;
                    last_h = cur_h;
                end
                cs_hi++;
                gap = 0;
            end

            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", 1, 0, "done with no frame outstanding");
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(sample === e, "R6 R7", int'(sample), int'(e), "sample value");
                end
            end else if (sample !== res_p) begin
                res_moves++;
            end
            if (done_p) chk(done === 1'b0, "R8", int'(done), 0, "done width");

            sclk_p = sclk; cs_p = cs_n; done_p = done; res_p = sample;
        end
    end

    task automatic run_frame(input logic [9:0] v, input logic m, input int d,
                             input bit junk, input bit poke);
        logic [2:0] trail;
        @(negedge clk);
        idle_high = m;
        half_div  = DIV_W'(d);
        cur_h     = d + 1;
        trail     = {v[1], v[2], v[3]};
        // R7: ignored positions get set or inverted bits when junk is set
        word = junk ? {2'b11, 1'b1, v, ~trail} : {2'b01, 1'b0, v, trail};
        repeat (12) @(negedge clk);
        chk(sclk === m, "R4", int'(sclk), int'(m), "rest level before frame");
        exp_q.push_back(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n === 1'b0, "R2", int'(cs_n), 0, "chip select after start");
        if (poke) begin
            repeat (5 * (d + 1)) @(negedge clk);
            start = 1'b1;   // R9: repeated start mid-frame
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(sclk === m, "R4", int'(sclk), int'(m), "rest level at release");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1, "run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; half_div = '0; idle_high = 1'b0;
        repeat (4) @(negedge clk);
        chk(cs_n === 1'b1, "R1", int'(cs_n), 1, "cs_n in reset");
        chk(done === 1'b0, "R1", int'(done), 0, "done in reset");
        chk(sample === 10'd0, "R1", int'(sample), 0, "sample in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && done === 1'b0, "R1", int'(cs_n), 1, "idle after reset");

        run_frame(10'h3FF, 1'b0, 0, 1'b0, 1'b0);
        run_frame(10'h000, 1'b1, 0, 1'b1, 1'b0);
        run_frame(10'h2AA, 1'b0, 2, 1'b0, 1'b0);
        run_frame(10'h155, 1'b1, 3, 1'b1, 1'b0);
        run_frame(10'h201, 1'b0, 1, 1'b1, 1'b0);
        run_frame(10'h1FE, 1'b1, 1, 1'b0, 1'b0);
        run_frame(10'h0F0, 1'b0, 2, 1'b1, 1'b1);
        run_frame(10'h30C, 1'b1, 4, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            run_frame(10'($urandom), 1'($urandom), int'($urandom % 6), 1'($urandom), 1'b0);
        end

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0, "outstanding frames");
        chk(cs_n === 1'b1 && done === 1'b0, "R8", int'(done), 0, "quiet after last frame");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule